// File: doc/BRIEF.md
# Accumulator Processor Core

This block is a small accumulator processor. It has a program counter, an accumulator, an instruction register, an ALU and a control unit. It reaches one shared memory through an address bus, separate read and write data buses, a request strobe and a read/not-write line. The memory has to return read data in the same cycle as the address. Each instruction word carries a 4-bit opcode in its top bits and an operand address S in its low `ADDR_W` bits.

The control unit keeps one state bit that tells an execute cycle from a fetch cycle. An instruction costs exactly as many cycles as it makes memory accesses. The ALU also increments the fetch address, so the fetch of the next instruction overlaps the end of the current one. A jump resolves inside the fetch cycle that reads from its target. A stop instruction parks the core with a halted status until the next reset.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst` is high, `mem_req` and `halted` are low. The first cycle after `rst` falls is a read fetch (`mem_req`=1, `mem_rnw`=1) from address 0.
- R2: Opcode 0000 (load, opcode in bits DATA_W-1:DATA_W-4, S in bits ADDR_W-1:0) takes two cycles and sets ACC to Mem[S].
- R3: Opcode 0001 (store) takes two cycles. In its execute cycle `mem_addr`=S, `mem_rnw`=0 and `mem_wdata`=ACC. ACC is unchanged.
- R4: Opcodes 0010 (add) and 0011 (subtract) take two cycles and set ACC to ACC+Mem[S] or ACC−Mem[S], modulo 2^DATA_W.
- R5: Every fetch reads memory, loads the IR and sets PC to the fetch address plus one, modulo 2^ADDR_W. Opcodes 0100 to 1111 get no execute cycle.
- R6: Opcode 0100 (jump) costs one cycle: the fetch that follows it reads from S.
- R7: Opcode 0101 is taken when ACC bit DATA_W-1 is 0 (next fetch from S). Otherwise the next fetch reads from PC.
- R8: Opcode 0110 is taken when ACC is nonzero. Otherwise the next fetch reads from PC.
- R9: After opcode 0111 is fetched, the next cycle makes no memory access. `halted` then rises and stays high, with no memory access and no ACC change, until reset.
- R10: Opcodes 1000 to 1111 do nothing: one cycle, and the next fetch reads from PC.
- R11: `mem_rnw` is low only in a store's execute cycle. `mem_wdata` is zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | ADDR_W | Memory address (PC or operand S) |
| mem_rdata | input | DATA_W | Read data, valid in the same cycle |
| mem_wdata | output | DATA_W | Write data (ACC during a store, else zero) |
| mem_req | output | 1 | Memory access this cycle |
| mem_rnw | output | 1 | 1 = read, 0 = write |
| halted | output | 1 | Core stopped by the stop opcode |
| acc_value | output | DATA_W | Current accumulator contents |

## Verification
The bench builds the core with DATA_W=16, ADDR_W=8 and the shared-adder ALU. The 8-bit address gives a 256-word behavioural memory, which puts the program counter's wrap from 0xFF to 0x00 within reach of a two-word program. At 16 bits the sign bit and the modulo wrap of add and subtract sit at the usual positions. The separate-operator ALU variant is only elaborated when the parameter selects it.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   localparam int OPC_W = 4;

   typedef enum logic [OPC_W-1:0] {
      OP_LOAD  = 4'h0,
      OP_STORE = 4'h1,
      OP_ADD   = 4'h2,
      OP_SUB   = 4'h3,
      OP_JUMP  = 4'h4,
      OP_JPOS  = 4'h5,
      OP_JNZ   = 4'h6,
      OP_STOP  = 4'h7
   } opcode_e;

   typedef enum logic [2:0] {
      FN_ZERO,
      FN_PASS_B,
      FN_ADD,
      FN_SUB,
      FN_INC_B
   } alu_fn_e;

   // Opcodes 0..3 need a second memory access for the operand
   function automatic logic has_operand(input logic [OPC_W-1:0] op);
      return op[3:2] == 2'b00;
   endfunction

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter bit SHARED = 1'b1
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  alu_fn_e           fn,
   output logic [DATA_W-1:0] y
);

   localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

   generate
      if (SHARED) begin : g_shared
         // One carry chain: conditioned operands plus carry-in
         logic [DATA_W-1:0] opa;
         logic [DATA_W-1:0] opb;
         logic              cin;
         always_comb begin
            opa = (fn == FN_ADD || fn == FN_SUB) ? a : '0;
            opb = (fn == FN_SUB) ? ~b : b;
            cin = (fn == FN_SUB || fn == FN_INC_B);
            y   = (fn == FN_ZERO) ? '0 : (opa + opb + {{(DATA_W-1){1'b0}}, cin});
         end
      end else begin : g_split
         always_comb begin
            case (fn)
               FN_PASS_B: y = b;
               FN_ADD:    y = a + b;
               FN_SUB:    y = a - b;
               FN_INC_B:  y = b + ONE;
               default:   y = '0;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/acc_cpu_regs.sv
module acc_cpu_regs #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] alu_y,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              acc_en,
   input  logic              pc_en,
   input  logic              ir_en,
   input  logic              addr_from_ir,
   output logic [ADDR_W-1:0] pc,
   output logic [DATA_W-1:0] acc,
   output logic [DATA_W-1:0] ir,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              acc_zero,
   output logic              acc_neg
);

   // PC has no reset of its own: reset forces the ALU to zero and enables the load
   always_ff @(posedge clk) begin
      if (pc_en) pc <= alu_y[ADDR_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst)         acc <= '0;
      else if (acc_en) acc <= alu_y;
   end

   always_ff @(posedge clk) begin
      if (rst)        ir <= '0;
      else if (ir_en) ir <= mem_rdata;
   end

   assign mem_addr = addr_from_ir ? ir[ADDR_W-1:0] : pc;
   assign acc_zero = (acc == '0);
   assign acc_neg  = acc[DATA_W-1];

   assert_pc_cleared_R1: assert property (@(posedge clk) rst |=> (pc == '0));

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
   import acc_cpu_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic [OPC_W-1:0] ir_op,
   input  logic [OPC_W-1:0] fetched_op,
   input  logic             acc_zero,
   input  logic             acc_neg,
   output logic             ex,
   output logic             halted,
   output logic             addr_from_ir,
   output logic             b_from_addr,
   output logic             acc_en,
   output logic             pc_en,
   output logic             ir_en,
   output logic             acc_oe,
   output alu_fn_e          alu_fn,
   output logic             mem_req,
   output logic             mem_rnw
);

   logic take;
   logic stop_now;

   always_comb begin
      case (opcode_e'(ir_op))
         OP_JUMP: take = 1'b1;
         OP_JPOS: take = ~acc_neg;
         OP_JNZ:  take = ~acc_zero;
         default: take = 1'b0;
      endcase
   end

   assign stop_now = ~ex & (ir_op == OP_STOP);

   always_comb begin
      addr_from_ir = 1'b0;
      b_from_addr  = 1'b0;
      acc_en       = 1'b0;
      pc_en        = 1'b0;
      ir_en        = 1'b0;
      acc_oe       = 1'b0;
      alu_fn       = FN_ZERO;
      mem_req      = 1'b0;
      mem_rnw      = 1'b1;
      if (rst) begin
         pc_en = 1'b1;                  // load the forced zero into PC
      end else if (halted || stop_now) begin
         // parked: no access, no register update
      end else if (ex) begin
         addr_from_ir = 1'b1;
         mem_req      = 1'b1;
         case (opcode_e'(ir_op))
            OP_STORE: begin mem_rnw = 1'b0; acc_oe = 1'b1; end
            OP_LOAD:  begin alu_fn = FN_PASS_B; acc_en = 1'b1; end
            OP_ADD:   begin alu_fn = FN_ADD;    acc_en = 1'b1; end
            OP_SUB:   begin alu_fn = FN_SUB;    acc_en = 1'b1; end
            default:  ;
         endcase
      end else begin
         addr_from_ir = take;
         b_from_addr  = 1'b1;
         alu_fn       = FN_INC_B;
         pc_en        = 1'b1;
         ir_en        = 1'b1;
         mem_req      = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ex     <= 1'b0;
         halted <= 1'b0;
      end else if (!halted) begin
         ex     <= ~ex & ~stop_now & has_operand(fetched_op);
         halted <= stop_now;
      end
   end

   assert_exec_single_R2: assert property (@(posedge clk) disable iff (rst)
      ex |=> !ex);
   assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (rst)
      halted |=> halted);
   assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (rst)
      halted |-> (!mem_req && !acc_en && !pc_en && !ir_en));
   assert_write_only_exec_R11: assert property (@(posedge clk) disable iff (rst)
      (mem_req && !mem_rnw) |-> (ex && acc_oe && ir_op == OP_STORE));

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 12,
   parameter bit ALU_SHARED = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_req,
   output logic              mem_rnw,
   output logic              halted,
   output logic [DATA_W-1:0] acc_value
);

   localparam int PAD_W = DATA_W - ADDR_W;

   generate
      if (DATA_W < OPC_W + ADDR_W) begin : g_bad_width
         $error("acc_cpu_core: DATA_W must hold opcode and address");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("acc_cpu_core: ADDR_W too small");
      end
   endgenerate

   logic [ADDR_W-1:0] pc;
   logic [DATA_W-1:0] acc;
   logic [DATA_W-1:0] ir;
   logic [DATA_W-1:0] alu_b;
   logic [DATA_W-1:0] alu_y;
   logic              acc_zero, acc_neg;
   logic              ex, addr_from_ir, b_from_addr;
   logic              acc_en, pc_en, ir_en, acc_oe;
   alu_fn_e           alu_fn;
   logic [OPC_W-1:0]  ir_op;
   logic [ADDR_W-1:0] ir_s;

   assign ir_op = ir[DATA_W-1 -: OPC_W];
   assign ir_s  = ir[ADDR_W-1:0];

   acc_cpu_ctrl u_ctrl (
      .clk          (clk),
      .rst          (rst),
      .ir_op        (ir_op),
      .fetched_op   (mem_rdata[DATA_W-1 -: OPC_W]),
      .acc_zero     (acc_zero),
      .acc_neg      (acc_neg),
      .ex           (ex),
      .halted       (halted),
      .addr_from_ir (addr_from_ir),
      .b_from_addr  (b_from_addr),
      .acc_en       (acc_en),
      .pc_en        (pc_en),
      .ir_en        (ir_en),
      .acc_oe       (acc_oe),
      .alu_fn       (alu_fn),
      .mem_req      (mem_req),
      .mem_rnw      (mem_rnw)
   );

   acc_cpu_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk          (clk),
      .rst          (rst),
      .alu_y        (alu_y),
      .mem_rdata    (mem_rdata),
      .acc_en       (acc_en),
      .pc_en        (pc_en),
      .ir_en        (ir_en),
      .addr_from_ir (addr_from_ir),
      .pc           (pc),
      .acc          (acc),
      .ir           (ir),
      .mem_addr     (mem_addr),
      .acc_zero     (acc_zero),
      .acc_neg      (acc_neg)
   );

   // B input: the address bus for increments, memory data for operands
   assign alu_b = b_from_addr ? {{PAD_W{1'b0}}, mem_addr} : mem_rdata;

   acc_cpu_alu #(.DATA_W(DATA_W), .SHARED(ALU_SHARED)) u_alu (
      .a  (acc),
      .b  (alu_b),
      .fn (alu_fn),
      .y  (alu_y)
   );

   assign mem_wdata = acc_oe ? acc : '0;
   assign acc_value = acc;

   assert_store_bus_R3: assert property (@(posedge clk) disable iff (rst)
      (mem_req && !mem_rnw) |-> (mem_wdata == acc && mem_addr == ir_s));
   assert_store_keeps_acc_R3: assert property (@(posedge clk) disable iff (rst)
      (ex && ir_op == OP_STORE) |=> (acc == $past(acc)));
   assert_add_result_R4: assert property (@(posedge clk) disable iff (rst)
      (ex && ir_op == OP_ADD) |=> (acc == $past(acc) + $past(mem_rdata)));
   assert_sub_result_R4: assert property (@(posedge clk) disable iff (rst)
      (ex && ir_op == OP_SUB) |=> (acc == $past(acc) - $past(mem_rdata)));
   assert_fetch_step_R5: assert property (@(posedge clk) disable iff (rst)
      (mem_req && mem_rnw && !ex) |=> (pc == $past(mem_addr) + 1'b1));
   assert_jump_target_R6: assert property (@(posedge clk) disable iff (rst)
      (!ex && !halted && ir_op == OP_JUMP) |-> (mem_addr == ir_s));
   assert_jpos_pick_R7: assert property (@(posedge clk) disable iff (rst)
      (!ex && !halted && ir_op == OP_JPOS) |->
         (mem_addr == (acc[DATA_W-1] ? pc : ir_s)));
   assert_jnz_pick_R8: assert property (@(posedge clk) disable iff (rst)
      (!ex && !halted && ir_op == OP_JNZ) |->
         (mem_addr == ((acc == '0) ? pc : ir_s)));

endmodule

// File: tb/acc_cpu_core_test.sv
module acc_cpu_core_test;

   typedef struct packed {
      logic [3:0]  op;
      logic [15:0] x;
      logic [15:0] y;
      logic [15:0] e_acc;
      logic [15:0] e_res;
      logic [15:0] e_y;
      logic [7:0]  e_cyc;
      logic [3:0]  e_wr;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t TABLE [NV] = '{
      '{4'h0, 16'h1234, 16'hBEEF, 16'hBEEF, 16'hBEEF, 16'hBEEF, 8'd8, 4'd1},
      '{4'h1, 16'h0F0F, 16'h5555, 16'h0F0F, 16'h0F0F, 16'h0F0F, 8'd8, 4'd2},
      '{4'h2, 16'h7FFF, 16'h0001, 16'h8000, 16'h8000, 16'h0001, 8'd8, 4'd1},
      '{4'h2, 16'hFFFF, 16'h0002, 16'h0001, 16'h0001, 16'h0002, 8'd8, 4'd1},
      '{4'h3, 16'h0005, 16'h0007, 16'hFFFE, 16'hFFFE, 16'h0007, 8'd8, 4'd1},
      '{4'h4, 16'h8000, 16'h0000, 16'h7777, 16'h7777, 16'h0000, 8'd9, 4'd1},
      '{4'h5, 16'h0000, 16'h1111, 16'h7777, 16'h7777, 16'h1111, 8'd9, 4'd1},
      '{4'h5, 16'h8000, 16'h1111, 16'h8000, 16'h8000, 16'h1111, 8'd7, 4'd1},
      '{4'h6, 16'h0000, 16'h2222, 16'h0000, 16'h0000, 16'h2222, 8'd7, 4'd1},
      '{4'h6, 16'h0001, 16'h2222, 16'h7777, 16'h7777, 16'h2222, 8'd9, 4'd1},
      '{4'h9, 16'h1357, 16'h3333, 16'h1357, 16'h1357, 16'h3333, 8'd7, 4'd1},
      '{4'h7, 16'h2468, 16'h4444, 16'h2468, 16'hDEAD, 16'h4444, 8'd4, 4'd0}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  mem_addr;
   logic [15:0] mem_rdata, mem_wdata, acc_value;
   logic        mem_req, mem_rnw, halted;

   logic [15:0] mem [256];
   logic        ld_en = 1'b0;
   logic [7:0]  ld_addr = '0;
   logic [15:0] ld_data = '0;
   int          wr_cnt;
   int          checks = 0;
   int          errors = 0;

   always #5 clk = ~clk;

   acc_cpu_core #(.DATA_W(16), .ADDR_W(8), .ALU_SHARED(1'b1)) uut (
      .clk       (clk),
      .rst       (rst),
      .mem_addr  (mem_addr),
      .mem_rdata (mem_rdata),
      .mem_wdata (mem_wdata),
      .mem_req   (mem_req),
      .mem_rnw   (mem_rnw),
      .halted    (halted),
      .acc_value (acc_value)
   );

   assign mem_rdata = mem[mem_addr];

   always @(posedge clk) begin
      if (ld_en)                     mem[ld_addr] <= ld_data;
      else if (mem_req && !mem_rnw)  mem[mem_addr] <= mem_wdata;
      if (rst)                       wr_cnt <= 0;
      else if (mem_req && !mem_rnw)  wr_cnt <= wr_cnt + 1;
   end

   task automatic chk(input bit ok, input string tag,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic put(input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      ld_en = 1'b1; ld_addr = a; ld_data = d;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   function automatic string tag_of(input logic [3:0] op);
      case (op)
         4'h0:        return "R2 load";
         4'h1:        return "R3 store";
         4'h2, 4'h3:  return "R4 arith";
         4'h4:        return "R6 jump";
         4'h5:        return "R7 jpos";
         4'h6:        return "R8 jnz";
         4'h7:        return "R9 stop";
         default:     return "R10 undefined";
      endcase
   endfunction

   task automatic run_vec(input vec_t v);
      logic [7:0] s;
      int cyc;
      rst = 1'b1;
      s = (v.op == 4'h4 || v.op == 4'h5 || v.op == 4'h6) ? 8'h05 : 8'h41;
      put(8'h00, 16'h0040);
      put(8'h01, {v.op, 4'h0, s});
      put(8'h02, 16'h1050);
      put(8'h03, 16'h7000);
      put(8'h04, 16'h7000);
      put(8'h05, 16'h0042);
      put(8'h06, 16'h1050);
      put(8'h07, 16'h7000);
      put(8'h40, v.x);
      put(8'h41, v.y);
      put(8'h42, 16'h7777);
      put(8'h50, 16'hDEAD);
      @(negedge clk);
      chk(!mem_req && !halted, "R1 idle in reset", {mem_req, halted}, 0);
      rst = 1'b0;
      #1;
      chk(mem_addr == 8'h00 && mem_req && mem_rnw, "R1 first fetch",
          {mem_req, mem_rnw, mem_addr}, {2'b11, 8'h00});
      cyc = 0;
      while (!halted && cyc < 40) begin
         @(posedge clk);
         @(negedge clk);
         cyc++;
      end
      chk(cyc == int'(v.e_cyc), tag_of(v.op), cyc, v.e_cyc);
      chk(acc_value == v.e_acc, tag_of(v.op), acc_value, v.e_acc);
      chk(mem[8'h50] == v.e_res, tag_of(v.op), mem[8'h50], v.e_res);
      chk(mem[8'h41] == v.e_y, tag_of(v.op), mem[8'h41], v.e_y);
      chk(wr_cnt == int'(v.e_wr), "R11 write count", wr_cnt, v.e_wr);
      repeat (5) @(negedge clk);
      chk(halted && !mem_req && acc_value == v.e_acc, "R9 halt holds",
          {halted, mem_req, acc_value}, {2'b10, v.e_acc});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      for (int i = 0; i < NV; i++) run_vec(TABLE[i]);

      // Directed: jump to the top address, PC wraps to zero (R5, R6)
      rst = 1'b1;
      put(8'h00, 16'h40FF);
      put(8'hFF, 16'h8000);
      @(negedge clk);
      rst = 1'b0;
      #1;
      chk(mem_addr == 8'h00, "R1 wrap start", mem_addr, 8'h00);
      @(negedge clk);
      chk(mem_addr == 8'hFF && mem_req && mem_rnw, "R6 jump to top",
          mem_addr, 8'hFF);
      @(negedge clk);
      chk(mem_addr == 8'h00 && mem_req, "R5 pc wrap", mem_addr, 8'h00);
      // Reset in the middle of a run
      rst = 1'b1;
      #1;
      chk(!mem_req && !halted, "R1 reset mid-run", {mem_req, halted}, 0);
      @(negedge clk);
      rst = 1'b0;
      #1;
      chk(mem_addr == 8'h00 && mem_req && mem_rnw, "R1 restart at zero",
          mem_addr, 8'h00);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule